// File: doc/BRIEF.md
# Memory-Mapped Configuration Request Bridge

This block sits on the root side of a PCI Express link and turns single-beat memory-mapped reads and writes into configuration requests. A 14-bit slave address either selects a small bank of local registers or starts a configuration access. The target bus, device and function for every configuration access come from a local register that software loads beforehand. The access itself then goes to the register offset carried in the low address bits.

Every configuration request is non-posted and carries the same fixed tag. At most one request is in flight at a time. The slave keeps its wait signal high from the moment a configuration access is presented until the matching completion has been consumed or a timeout has expired. Only then does it accept the access. For a read, it returns the data one cycle after accepting it. A failed status or a missing completion sets a sticky bit in an error register and returns all-ones data. The single request slot is freed in both cases.

Top module: `cfg_req_bridge`

## Requirements
- R1: Address bit 13 set selects the local registers, and such accesses never stall. The word at `s_addr[11:2]` = 0 is a 32-bit read/write scratch word. Word 1 holds the 16-bit target ID {bus[7:0], device[4:0], function[2:0]} in bits [15:0] and reads upper bits as zero. Word 2 is the error register. Local writes ignore the byte enables. Any accepted read returns data with `s_rvalid` high one cycle after acceptance.
- R2: With bit 13 clear and `s_read` high, one request is sent on `tx_data`. Dword 0 is `tx_data[31:0]` and holds Fmt/Type in [31:24]: 0x04, or 0x05 when address bit 12 is set. Its length field [9:0] is 1. Dword 1 (`tx_data[63:32]`) holds requester ID [31:16], tag 0xFF in [15:8], last byte enables 0 in [7:4] and `s_be` in [3:0]. Dword 2 (`tx_data[95:64]`) holds the target ID in [31:16] and `s_addr[11:2]` in [11:2], with zero everywhere else. Address bits [1:0] have no effect.
- R3: A write with bit 13 clear sends the same layout with Fmt/Type 0x44, or 0x45 when address bit 12 is set. `s_wdata` goes in dword 3 (`tx_data[127:96]`). For a read, dword 3 is zero.
- R4: `s_wait` stays high from the cycle a configuration access appears until the completion or timeout has been processed. `tx_valid` with its data stays stable until `tx_ready`. Only one request is sent per access.
- R5: A completion on `rx_data` is consumed only while a request is outstanding. It must also carry tag `rx_data[79:72]` = 0xFF and Fmt/Type `rx_data[31:24]` equal to 0x0A (Cpl) or 0x4A (CplD). Any other beat is ignored.
- R6: A CplD with successful status (`rx_data[47:45]` = 0) returns its payload `rx_data[127:96]` on `s_rdata`.
- R7: A successful Cpl finishes a write without setting an error. For a read, a successful Cpl returns all-ones.
- R8: A non-zero completion status sets error bit 0 and returns all-ones read data.
- R9: If no completion is consumed within TMO_CYCLES cycles of waiting, error bit 1 is set, all-ones is returned and the slot is freed. A completion arriving after that is ignored.
- R10: Error bits are cleared only by writing 1 to them at word 2. Writing 0 leaves them unchanged.
- R11: A valid completion in the last waiting cycle wins over the timeout: its data is returned and no timeout bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_addr | input | 14 | Slave word/byte address |
| s_write | input | 1 | Slave write request |
| s_read | input | 1 | Slave read request |
| s_wdata | input | 32 | Slave write data |
| s_be | input | 4 | Slave byte enables |
| s_wait | output | 1 | Stall; request held while high |
| s_rdata | output | 32 | Read data |
| s_rvalid | output | 1 | Read data valid |
| tx_valid | output | 1 | Request beat valid |
| tx_ready | input | 1 | Request beat accepted |
| tx_data | output | 128 | Request header and data, dword 0 in low bits |
| rx_valid | input | 1 | Completion beat valid |
| rx_data | input | 128 | Completion header and payload, dword 0 in low bits |

## Verification
Two events can fall in the same cycle: a matching completion being consumed, and the wait counter reaching its limit. The bench provokes this by presenting a good CplD so that it is sampled on exactly the last edge of the waiting window. It then expects the payload on the read bus and the timeout bit still clear. A neighbouring run withholds the completion altogether and later sends a stale one after the slot has been freed. In that run, the timeout bit and all-ones data must appear, and the stale beat must not disturb the next access.

// File: rtl/cfg_req_bridge.sv
module cfg_req_bridge #(
  parameter int          TMO_CYCLES = 1024,
  parameter logic [15:0] REQ_ID     = 16'h0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [13:0]  s_addr,
  input  logic         s_write,
  input  logic         s_read,
  input  logic [31:0]  s_wdata,
  input  logic [3:0]   s_be,
  output logic         s_wait,
  output logic [31:0]  s_rdata,
  output logic         s_rvalid,
  output logic         tx_valid,
  input  logic         tx_ready,
  output logic [127:0] tx_data,
  input  logic         rx_valid,
  input  logic [127:0] rx_data
);
  localparam int         CW    = $clog2(TMO_CYCLES + 1);
  localparam logic [7:0] TAG   = 8'hFF;
  localparam logic [7:0] T_CPL = 8'h0A;
  localparam logic [7:0] T_CPD = 8'h4A;

  typedef enum logic [1:0] {IDLE, SEND, WAIT, DONE} st_t;

  st_t          st;
  logic [127:0] tlp_q;
  logic [CW-1:0] tmo_cnt;
  logic [31:0]  cpl_q;
  logic [31:0]  scratch;
  logic [15:0]  tgt_id;
  logic [1:0]   err;

  wire is_local = s_addr[13];
  wire cfg_req  = (s_read | s_write) & ~is_local;
  wire loc_wr   = s_write & is_local;
  wire [9:0] word = s_addr[11:2];

  assign s_wait   = cfg_req & (st != DONE);
  assign tx_valid = (st == SEND);
  assign tx_data  = tlp_q;

  wire [7:0] rx_type   = rx_data[31:24];
  wire [2:0] rx_status = rx_data[47:45];
  wire [7:0] rx_tag    = rx_data[79:72];

  wire claim  = (st == WAIT) & rx_valid & (rx_tag == TAG) &
                ((rx_type == T_CPL) | (rx_type == T_CPD));
  wire expire = (st == WAIT) & ~claim & (tmo_cnt == CW'(TMO_CYCLES - 1));

  wire [7:0]  fmt_type = {1'b0, ~s_read, 3'b000, 2'b10, s_addr[12]};
  wire [31:0] dw0 = {fmt_type, 14'd0, 10'd1};
  wire [31:0] dw1 = {REQ_ID, TAG, 4'h0, s_be};
  wire [31:0] dw2 = {tgt_id, 4'h0, s_addr[11:2], 2'b00};
  wire [31:0] dw3 = s_read ? 32'h0 : s_wdata;

  wire [1:0] w1c     = (loc_wr && word == 10'd2) ? s_wdata[1:0] : 2'b00;
  wire [1:0] err_set = {expire, claim & (rx_status != 3'd0)};

  logic [31:0] loc_rdata;
  always_comb begin
    case (word)
      10'd0:   loc_rdata = scratch;
      10'd1:   loc_rdata = {16'h0, tgt_id};
      10'd2:   loc_rdata = {30'h0, err};
      default: loc_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      tlp_q   <= '0;
      tmo_cnt <= '0;
      cpl_q   <= '0;
    end else begin
      case (st)
        IDLE: if (cfg_req) begin
          tlp_q <= {dw3, dw2, dw1, dw0};
          st    <= SEND;
        end
        SEND: if (tx_ready) begin
          tmo_cnt <= '0;
          st      <= WAIT;
        end
        WAIT: begin
          if (claim) begin
            cpl_q <= (rx_status == 3'd0 && rx_type == T_CPD) ? rx_data[127:96] : 32'hFFFF_FFFF;
            st    <= DONE;
          end else if (expire) begin
            cpl_q <= 32'hFFFF_FFFF;
            st    <= DONE;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scratch <= '0;
      tgt_id  <= '0;
      err     <= '0;
    end else begin
      if (loc_wr && word == 10'd0) scratch <= s_wdata;
      if (loc_wr && word == 10'd1) tgt_id  <= s_wdata[15:0];
      err <= (err & ~w1c) | err_set;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else begin
      s_rvalid <= s_read & ~s_wait;
      if (s_read & ~s_wait) s_rdata <= is_local ? loc_rdata : cpl_q;
    end
  end
endmodule

// File: rtl/cfg_req_bridge_chk.sv
module cfg_req_bridge_chk (
  input logic         clk,
  input logic         rst_n,
  input logic [13:0]  s_addr,
  input logic         s_read,
  input logic         s_write,
  input logic         s_wait,
  input logic         s_rvalid,
  input logic         tx_valid,
  input logic         tx_ready,
  input logic [127:0] tx_data
);
  assert_hdr_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_data[47:40] == 8'hFF && tx_data[9:0] == 10'd1 && tx_data[39:36] == 4'h0));

  assert_fmt_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_data[31:24] == 8'h04 || tx_data[31:24] == 8'h05 ||
                  tx_data[31:24] == 8'h44 || tx_data[31:24] == 8'h45));

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_valid);

  assert_stall_while_sending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && (s_read || s_write) && !s_addr[13] |-> s_wait);

  assert_rvalid_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> $past(s_read && !s_wait));
endmodule

bind cfg_req_bridge cfg_req_bridge_chk chk_i (
  .clk(clk), .rst_n(rst_n), .s_addr(s_addr), .s_read(s_read), .s_write(s_write),
  .s_wait(s_wait), .s_rvalid(s_rvalid), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data)
);

// File: tb/cfg_req_bridge_tb_top.sv
module cfg_req_bridge_tb_top;
  localparam int T = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [13:0]  s_addr;
  logic         s_write, s_read;
  logic [31:0]  s_wdata;
  logic [3:0]   s_be;
  logic         s_wait;
  logic [31:0]  s_rdata;
  logic         s_rvalid;
  logic         tx_valid, tx_ready;
  logic [127:0] tx_data;
  logic         rx_valid;
  logic [127:0] rx_data;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cfg_req_bridge #(.TMO_CYCLES(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_addr(s_addr), .s_write(s_write), .s_read(s_read),
    .s_wdata(s_wdata), .s_be(s_be), .s_wait(s_wait), .s_rdata(s_rdata),
    .s_rvalid(s_rvalid), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_cpl(input logic [7:0] ty, input logic [2:0] stat,
                                          input logic [7:0] tag, input logic [31:0] pay);
    return {pay, {16'h0000, tag, 8'h00}, {16'h0000, stat, 1'b0, 12'd4}, {ty, 14'd0, 10'd1}};
  endfunction

  function automatic logic [127:0] exp_tlp(input bit rd, input logic [13:0] a, input logic [3:0] be,
                                           input logic [31:0] wd, input logic [15:0] id);
    logic [7:0] ft;
    ft = (rd ? 8'h04 : 8'h44) | {7'd0, a[12]};
    return {(rd ? 32'h0 : wd), {id, 4'h0, a[11:2], 2'b00}, {16'h0000, 8'hFF, 4'h0, be},
            {ft, 14'd0, 10'd1}};
  endfunction

  task automatic loc_wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    s_addr = a; s_wdata = d; s_be = 4'hF; s_write = 1'b1;
    #1 chk("R1 local write no stall", s_wait, 1'b0);
    @(negedge clk);
    s_write = 1'b0;
  endtask

  task automatic loc_rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    s_addr = a; s_read = 1'b1;
    #1 chk("R1 local read no stall", s_wait, 1'b0);
    @(negedge clk);
    chk("R1 rvalid after one cycle", s_rvalid, 1'b1);
    d = s_rdata;
    s_read = 1'b0;
  endtask

  task automatic cfg_op(input bit rd, input logic [13:0] a, input logic [3:0] be,
                        input logic [31:0] wd, input int hold, input int delay,
                        input bit decoy, input logic [127:0] cpl,
                        output logic [31:0] rdv, output logic [127:0] tlp);
    @(negedge clk);
    s_addr = a; s_be = be; s_wdata = wd; tx_ready = (hold == 0);
    if (rd) s_read = 1'b1; else s_write = 1'b1;
    #1 chk("R4 stall on config request", s_wait, 1'b1);
    @(negedge clk);
    chk("R4 request valid", tx_valid, 1'b1);
    tlp = tx_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R4 request held under backpressure", {tx_valid, tx_data}, {1'b1, tlp});
    end
    tx_ready = 1'b1;
    @(negedge clk);
    chk("R4 single request, still stalled", {tx_valid, s_wait}, 2'b01);
    if (decoy) begin
      rx_valid = 1'b1;
      rx_data = mk_cpl(8'h4A, 3'd0, 8'h12, 32'hBAD0_BAD0);
      @(negedge clk);
      rx_data = mk_cpl(8'h00, 3'd0, 8'hFF, 32'hBAD1_BAD1);
      @(negedge clk);
      rx_valid = 1'b0;
      chk("R5 wrong tag or type ignored", s_wait, 1'b1);
    end
    if (delay >= 0) begin
      repeat (delay) @(negedge clk);
      rx_valid = 1'b1; rx_data = cpl;
      @(negedge clk);
      rx_valid = 1'b0;
    end else begin
      for (int i = 0; i < 4 * T && s_wait; i++) @(negedge clk);
    end
    chk("R4 released after completion", s_wait, 1'b0);
    @(negedge clk);
    s_read = 1'b0; s_write = 1'b0;
    rdv = 32'h0;
    if (rd) begin
      chk("R6 config read rvalid", s_rvalid, 1'b1);
      rdv = s_rdata;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R4 reset idle", {tx_valid, s_wait, s_rvalid}, 3'b000);
    loc_rd(14'h2000, d); chk("R1 scratch reset", d, 32'h0);
    loc_rd(14'h2004, d); chk("R1 target id reset", d, 32'h0);
    loc_rd(14'h2008, d); chk("R10 error reset", d, 32'h0);
  endtask

  task automatic t_local;
    logic [31:0] d;
    loc_wr(14'h2000, 32'hA5C3_1E77);
    loc_wr(14'h2004, 32'hFFFF_1234);
    loc_rd(14'h2000, d); chk("R1 scratch readback", d, 32'hA5C3_1E77);
    loc_rd(14'h3004, d); chk("R1 target id 16 bits", d, 32'h0000_1234);
  endtask

  task automatic t_read0;
    logic [31:0] d; logic [127:0] t;
    cfg_op(1, 14'h0013, 4'hF, 32'h0, 0, 2, 0, mk_cpl(8'h4A, 3'd0, 8'hFF, 32'hDEAD_BEEF), d, t);
    chk("R2 type0 read header", t, exp_tlp(1, 14'h0010, 4'hF, 32'h0, 16'h1234));
    chk("R6 CplD payload returned", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_write1;
    logic [31:0] d; logic [127:0] t;
    loc_wr(14'h2004, 32'h0000_8A3D);
    cfg_op(0, 14'h1F04, 4'b0011, 32'h0BAD_F00D, 0, 0, 0, mk_cpl(8'h0A, 3'd0, 8'hFF, 32'h0), d, t);
    chk("R3 type1 write header", t, exp_tlp(0, 14'h1F04, 4'b0011, 32'h0BAD_F00D, 16'h8A3D));
    loc_rd(14'h2008, d); chk("R7 Cpl write no error", d, 32'h0);
  endtask

  task automatic t_decoy;
    logic [31:0] d; logic [127:0] t;
    cfg_op(1, 14'h1ABC, 4'b1100, 32'h0, 3, 0, 1, mk_cpl(8'h4A, 3'd0, 8'hFF, 32'h1357_9BDF), d, t);
    chk("R2 type1 read header after backpressure", t, exp_tlp(1, 14'h1ABC, 4'b1100, 32'h0, 16'h8A3D));
    chk("R5 real completion after decoys", d, 32'h1357_9BDF);
    cfg_op(1, 14'h0040, 4'hF, 32'h0, 0, 1, 0, mk_cpl(8'h0A, 3'd0, 8'hFF, 32'h0), d, t);
    chk("R7 Cpl on read gives all-ones", d, 32'hFFFF_FFFF);
    loc_rd(14'h2008, d); chk("R7 Cpl on read no error", d, 32'h0);
  endtask

  task automatic t_bad_status;
    logic [31:0] d; logic [127:0] t;
    cfg_op(1, 14'h0100, 4'hF, 32'h0, 0, 0, 0, mk_cpl(8'h4A, 3'd1, 8'hFF, 32'h2468_ACE0), d, t);
    chk("R8 bad status all-ones", d, 32'hFFFF_FFFF);
    loc_rd(14'h2008, d); chk("R8 status error bit", d, 32'h1);
    loc_wr(14'h2008, 32'h0);
    loc_rd(14'h2008, d); chk("R10 write 0 keeps bit", d, 32'h1);
    loc_wr(14'h2008, 32'h1);
    loc_rd(14'h2008, d); chk("R10 write 1 clears bit", d, 32'h0);
  endtask

  task automatic t_timeout;
    logic [31:0] d; logic [127:0] t;
    cfg_op(1, 14'h0200, 4'hF, 32'h0, 0, -1, 0, '0, d, t);
    chk("R9 timeout all-ones", d, 32'hFFFF_FFFF);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = mk_cpl(8'h4A, 3'd0, 8'hFF, 32'h7777_7777);
    @(negedge clk);
    rx_valid = 1'b0;
    loc_rd(14'h2008, d); chk("R9 timeout error bit", d, 32'h2);
    cfg_op(1, 14'h0204, 4'hF, 32'h0, 0, 0, 0, mk_cpl(8'h4A, 3'd0, 8'hFF, 32'h0C0F_FEE0), d, t);
    chk("R9 slot freed, late completion ignored", d, 32'h0C0F_FEE0);
    loc_wr(14'h2008, 32'h2);
    loc_rd(14'h2008, d); chk("R10 timeout bit cleared", d, 32'h0);
  endtask

  task automatic t_race;
    logic [31:0] d; logic [127:0] t;
    cfg_op(1, 14'h0300, 4'hF, 32'h0, 0, T - 1, 0, mk_cpl(8'h4A, 3'd0, 8'hFF, 32'h5A5A_0F0F), d, t);
    chk("R11 last-cycle completion wins", d, 32'h5A5A_0F0F);
    loc_rd(14'h2008, d); chk("R11 no timeout bit", d, 32'h0);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R4 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; s_addr = '0; s_write = 1'b0; s_read = 1'b0; s_wdata = '0; s_be = '0;
    tx_ready = 1'b1; rx_valid = 1'b0; rx_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_local();
    t_read0();
    t_write1();
    t_decoy();
    t_bad_status();
    t_timeout();
    t_race();
    finish_run();
  end
endmodule